// File: doc/BRIEF.md
# Single/Double to 80-bit Extended Real Widening Unit

This unit converts IEEE 754 binary32 and binary64 operands into the 80-bit extended real format. A math unit uses that format as its only internal representation. The conversion changes the exponent bias to 16383 and writes out the integer bit of the significand. The narrower formats leave that bit implicit. The stored fraction is moved to the top of a 63-bit field and padded with zeros below.

Zeros, infinities and NaNs each map to their extended encodings. Subnormal inputs are normalized: a leading-zero count drives both the fraction shift and the exponent correction. Every binary32 and binary64 value has an exact 80-bit image, so the unit never rounds. For example, the binary32 pattern 0xBFA66666 is the nearest binary value to -1.3. It is reproduced bit for bit, not re-derived from the decimal number.

Operands enter on a valid/ready handshake with a format-select bit. Results leave two cycles later with an output valid strobe. The pipeline accepts one operand per cycle and has no output backpressure.

Top module: `xreal_widen`

## Requirements
- R1: `in_ready` is 1 whenever `rst` is 0 and 0 while `rst` is 1. An operand is taken on a rising clock edge only when `in_valid` and `in_ready` are both 1.
- R2: Each accepted operand produces exactly one cycle of `out_valid` = 1, two clock cycles after the edge that accepted it. This holds for back-to-back operands too. `out_valid` is 0 in every other cycle.
- R3: The output is laid out as sign at bit 79, a 15-bit biased exponent at bits 78:64, an explicit integer bit at bit 63 and a 63-bit fraction at bits 62:0. The output sign always equals the input sign.
- R4: For a normal input, the output exponent is the input exponent minus the input bias (127 or 1023) plus 16383. The integer bit is 1, and the input fraction sits at the top of bits 62:0 with zeros below. Examples: 0x3F800000 gives 0x3FFF8000000000000000, 0x40000000 gives 0x40008000000000000000, 0xBFA66666 gives 0xBFFFA666660000000000.
- R5: A zero input (exponent field 0 and fraction 0) gives exponent 0, integer bit 0 and fraction 0, with the sign kept.
- R6: An infinity (exponent field all ones, fraction 0) gives exponent 0x7FFF, integer bit 1 and fraction 0.
- R7: A NaN (exponent field all ones, fraction non-zero) gives exponent 0x7FFF and integer bit 1, with the input payload at the top of the output fraction.
- R8: A subnormal input is normalized. The leading 1 of the input fraction becomes the integer bit, the bits below it move to the top of the output fraction, and the exponent is 16383 - bias - (leading zeros of the fraction). The binary32 pattern 0x00000001 gives 0x3F6A8000000000000000.
- R9: A reset (`rst` = 1 at a clock edge) clears the pipeline. `out_valid` is 0 in the cycle after it.
- R10: `in_fmt` = 0 selects binary32 in `in_data[31:0]`, and `in_data[63:32]` has no effect on the result. `in_fmt` = 1 selects binary64 in `in_data[63:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present on `in_data` |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_fmt | input | 1 | 0 = binary32 in low half, 1 = binary64 |
| in_data | input | 64 | Operand bits |
| out_valid | output | 1 | `out_data` holds a result this cycle |
| out_data | output | 80 | Extended real result |

## Verification
The clocked properties assume that `in_valid`, `in_fmt` and `in_data` are stable around each rising edge and hold known values whenever `in_valid` is 1. They also assume that reset is held for at least one edge before the first operand. The stimulus changes inputs shortly after each rising edge and holds reset for several cycles. During reset it presents operands that must be refused. The traffic covers every input class in both formats, including garbage in the unused upper half of binary32 operands. It mixes back-to-back streams with random idle cycles, so the latency and sign properties see both dense and sparse traffic.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int DP_BIAS   = 1023;
    localparam int XR_EXP_W  = 15;
    localparam int XR_FRAC_W = 63;
    localparam int XR_BIAS   = 16383;
    localparam int IN_W      = 1 + DP_EXP_W + DP_FRAC_W;
    localparam int XR_W      = 1 + XR_EXP_W + 1 + XR_FRAC_W;
    localparam int LZ_W      = $clog2(DP_FRAC_W + 1);
    localparam int PAD_W     = XR_FRAC_W - DP_FRAC_W;
    localparam int SP_PAD_W  = DP_FRAC_W - SP_FRAC_W;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_SUB  = 2'd1,
        CLS_NORM = 2'd2,
        CLS_SPEC = 2'd3
    } cls_e;

    // operand after field extraction, binary32 already widened to binary64 layout
    typedef struct packed {
        logic                 sign;
        logic                 fmt;
        cls_e                 cls;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
        logic [LZ_W-1:0]      lz;
    } unp_t;

    typedef struct packed {
        logic                 sign;
        logic [XR_EXP_W-1:0]  exp;
        logic                 ibit;
        logic [XR_FRAC_W-1:0] frac;
    } xreal_t;

    function automatic logic [XR_EXP_W-1:0] bias_delta(input logic fmt);
        return fmt ? XR_EXP_W'(XR_BIAS - DP_BIAS) : XR_EXP_W'(XR_BIAS - SP_BIAS);
    endfunction

    function automatic logic [XR_EXP_W-1:0] rebias_norm(input logic fmt,
                                                         input logic [DP_EXP_W-1:0] e);
        return XR_EXP_W'(e) + bias_delta(fmt);
    endfunction

    // subnormal: value = 0.f * 2^(1-bias); leading 1 sits lz+1 places below the point
    function automatic logic [XR_EXP_W-1:0] rebias_sub(input logic fmt,
                                                        input logic [LZ_W-1:0] lz);
        return bias_delta(fmt) - XR_EXP_W'(lz);
    endfunction

endpackage

// File: rtl/xw_lzc.sv
module xw_lzc #(
    parameter int W  = 52,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // zero_run[i] is 1 when every bit from the MSB down to i is zero
    logic [W-1:0] zero_run;

    for (genvar i = 0; i < W; i++) begin : g_run
        assign zero_run[i] = ~|vec[W-1:i];
    end

    always_comb begin
        cnt = '0;
        for (int k = 0; k < W; k++) begin
            cnt = cnt + CW'(zero_run[k]);
        end
    end

endmodule

// File: rtl/xw_unpack.sv
module xw_unpack
    import xw_pkg::*;
(
    input  logic            fmt,
    input  logic [IN_W-1:0] data,
    output unp_t            unp
);
    localparam int SP_SIGN = SP_EXP_W + SP_FRAC_W;
    localparam int DP_SIGN = DP_EXP_W + DP_FRAC_W;

    logic                 sign;
    logic [DP_EXP_W-1:0]  exp;
    logic [DP_FRAC_W-1:0] frac;
    logic                 exp_max;
    logic [LZ_W-1:0]      lz;

    always_comb begin
        if (fmt) begin
            sign    = data[DP_SIGN];
            exp     = data[DP_SIGN-1 -: DP_EXP_W];
            frac    = data[DP_FRAC_W-1:0];
            exp_max = &data[DP_SIGN-1 -: DP_EXP_W];
        end else begin
            sign    = data[SP_SIGN];
            exp     = DP_EXP_W'(data[SP_SIGN-1 -: SP_EXP_W]);
            frac    = {data[SP_FRAC_W-1:0], {SP_PAD_W{1'b0}}};
            exp_max = &data[SP_SIGN-1 -: SP_EXP_W];
        end
    end

    xw_lzc #(.W(DP_FRAC_W), .CW(LZ_W)) u_lzc (
        .vec (frac),
        .cnt (lz)
    );

    always_comb begin
        unp.sign = sign;
        unp.fmt  = fmt;
        unp.exp  = exp;
        unp.frac = frac;
        unp.lz   = lz;
        if (exp_max)
            unp.cls = CLS_SPEC;
        else if (exp == '0 && frac == '0)
            unp.cls = CLS_ZERO;
        else if (exp == '0)
            unp.cls = CLS_SUB;
        else
            unp.cls = CLS_NORM;
    end

endmodule

// File: rtl/xw_pack.sv
module xw_pack
    import xw_pkg::*;
(
    input  unp_t   unp,
    output xreal_t res
);
    logic [LZ_W:0]        shamt;
    logic [DP_FRAC_W-1:0] norm_frac;

    // shift one past the leading 1 so it leaves the field and becomes the integer bit
    assign shamt     = {1'b0, unp.lz} + (LZ_W+1)'(1);
    assign norm_frac = unp.frac << shamt;

    always_comb begin
        res.sign = unp.sign;
        unique case (unp.cls)
            CLS_ZERO: begin
                res.exp  = '0;
                res.ibit = 1'b0;
                res.frac = '0;
            end
            CLS_SPEC: begin
                res.exp  = '1;
                res.ibit = 1'b1;
                res.frac = {unp.frac, {PAD_W{1'b0}}};
            end
            CLS_SUB: begin
                res.exp  = rebias_sub(unp.fmt, unp.lz);
                res.ibit = 1'b1;
                res.frac = {norm_frac, {PAD_W{1'b0}}};
            end
            default: begin
                res.exp  = rebias_norm(unp.fmt, unp.exp);
                res.ibit = 1'b1;
                res.frac = {unp.frac, {PAD_W{1'b0}}};
            end
        endcase
    end

endmodule

// File: rtl/xreal_widen.sv
module xreal_widen
    import xw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_fmt,
    input  logic [IN_W-1:0] in_data,
    output logic            out_valid,
    output logic [XR_W-1:0] out_data
);
    logic   accept;
    unp_t   unp_d, unp_q;
    logic   s1_vld;
    xreal_t res_d, res_q;
    logic   s2_vld;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    // stage 1: field extraction, classification, leading-zero count
    xw_unpack u_unpack (
        .fmt  (in_fmt),
        .data (in_data),
        .unp  (unp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
        end else begin
            s1_vld <= accept;
        end
        unp_q <= unp_d;
    end

    // stage 2: rebias, normalize, assemble
    xw_pack u_pack (
        .unp (unp_q),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld <= 1'b0;
        end else begin
            s2_vld <= s1_vld;
        end
        res_q <= res_d;
    end

    assign out_valid = s2_vld;
    assign out_data  = res_q;

    logic in_sign;
    assign in_sign = in_fmt ? in_data[IN_W-1] : in_data[SP_EXP_W+SP_FRAC_W];

    // R2
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 out_valid);

    // R2
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 2));

    // R3
    sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 (out_data[XR_W-1] == $past(in_sign, 2)));

    // R5
    zero_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[XR_W-2 -: XR_EXP_W] == '0)
            |-> (!out_data[XR_FRAC_W] && out_data[XR_FRAC_W-1:0] == '0));

    // R6
    spec_ibit_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && &out_data[XR_W-2 -: XR_EXP_W]) |-> out_data[XR_FRAC_W]);

    // R8
    normalized_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[XR_W-2 -: XR_EXP_W] != '0) |-> out_data[XR_FRAC_W]);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sim_xreal_widen.sv
`timescale 1ns/1ps
module sim_xreal_widen;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic        in_fmt;
    logic [63:0] in_data;
    logic        out_valid;
    logic [79:0] out_data;

    always #5 clk = ~clk;

    xreal_widen u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_fmt    (in_fmt),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int          pc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    string       cur_tag = "";
    bit          lit_en = 0;
    logic [79:0] lit_val = '0;

    int          due_q[$];
    logic [79:0] val_q[$];
    string       tag_q[$];

    // behavioural model of the conversion
    function automatic logic [79:0] ref_conv(input bit f, input logic [63:0] d, output string tag);
        int          mw   = f ? 52 : 23;
        int          bias = f ? 1023 : 127;
        int          emax = f ? 2047 : 255;
        int          e    = f ? int'(d[62:52]) : int'(d[30:23]);
        bit          s    = f ? d[63] : d[31];
        logic [63:0] m    = f ? {12'b0, d[51:0]} : {41'b0, d[22:0]};
        logic [63:0] sig  = m << (63 - mw);
        int          x;
        if (e == emax) begin
            x = 32767; sig[63] = 1'b1;
            tag = (m == 0) ? "R6" : "R7";
        end else if (e == 0 && m == 0) begin
            x = 0; sig = '0; tag = "R5";
        end else if (e == 0) begin
            x = 16383 + 1 - bias;
            while (!sig[63]) begin sig = sig << 1; x = x - 1; end
            tag = "R8";
        end else begin
            x = e - bias + 16383; sig[63] = 1'b1; tag = "R4";
        end
        return {s, x[14:0], sig};
    endfunction

    // acceptance model: taken when not in reset and valid is high (R1)
    always @(posedge clk) begin
        string t;
        logic [79:0] v;
        pc = pc + 1;
        if (rst === 1'b0 && in_valid === 1'b1) begin
            v = ref_conv(in_fmt, in_data, t);
            if (lit_en) v = lit_val;
            if (cur_tag != "") t = cur_tag;
            due_q.push_back(pc + 1);
            val_q.push_back(v);
            tag_q.push_back(t);
        end
    end

    always @(negedge clk) begin
        bit ev;
        if (pc > 0 && !done) begin
            checks++;
            if (in_ready !== ~rst) begin
                fails++;
                $display("FAIL R1: in_ready=%b expected %b", in_ready, ~rst);
            end
            ev = (due_q.size() > 0 && due_q[0] == pc);
            checks++;
            if (out_valid !== ev) begin
                fails++;
                $display("FAIL %s: out_valid=%b expected %b (cycle %0d)", rst ? "R9" : "R2", out_valid, ev, pc);
            end else if (ev) begin
                checks++;
                if (out_data !== val_q[0]) begin
                    fails++;
                    $display("FAIL %s: out_data=%h expected %h", tag_q[0], out_data, val_q[0]);
                end
            end
            if (ev) begin
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic send(input bit f, input logic [63:0] d, input string t = "",
                        input bit le = 0, input logic [79:0] lv = '0);
        @(posedge clk); #2;
        in_valid = 1'b1; in_fmt = f; in_data = d;
        cur_tag = t; lit_en = le; lit_val = lv;
    endtask

    task automatic idle();
        @(posedge clk); #2;
        in_valid = 1'b0; lit_en = 1'b0; cur_tag = "";
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_fmt = 1'b0; in_data = '0;
        repeat (2) @(posedge clk);
        #2;
        // R1: operand offered during reset must be refused
        in_valid = 1'b1; in_data = 64'h3F800000;
        repeat (2) @(posedge clk);
        #2; in_valid = 1'b0;
        @(posedge clk); #2; rst = 1'b0;
        idle();
        // R3 R4: literal layouts
        send(0, 64'h0000_0000_3F80_0000, "R3", 1, 80'h3FFF_8000_0000_0000_0000);
        send(0, 64'h0000_0000_4000_0000, "R4", 1, 80'h4000_8000_0000_0000_0000);
        send(0, 64'h0000_0000_BFA6_6666, "R4", 1, 80'hBFFF_A666_6600_0000_0000);
        send(1, 64'h3FF0_0000_0000_0000, "R4", 1, 80'h3FFF_8000_0000_0000_0000);
        // R5 R6 R7 R8 literals
        send(0, 64'h0000_0000_8000_0000, "R5", 1, 80'h8000_0000_0000_0000_0000);
        send(0, 64'h0000_0000_7F80_0000, "R6", 1, 80'h7FFF_8000_0000_0000_0000);
        send(0, 64'h0000_0000_0000_0001, "R8", 1, 80'h3F6A_8000_0000_0000_0000);
        idle(); idle();
        // R10: garbage in upper half of binary32 operands
        send(0, 64'hDEAD_BEEF_3F80_0000, "R10", 1, 80'h3FFF_8000_0000_0000_0000);
        send(0, 64'hFFFF_FFFF_0000_0000, "R10", 1, 80'h0000_0000_0000_0000_0000);
        // class corners, both formats, via model
        send(1, 64'h0000_0000_0000_0000);
        send(1, 64'h8000_0000_0000_0000);
        send(1, 64'h7FF0_0000_0000_0000);
        send(1, 64'hFFF8_0000_0000_0001);
        send(0, 64'h7FC0_0001);
        send(1, 64'h0000_0000_0000_0001);
        send(1, 64'h000F_FFFF_FFFF_FFFF);
        send(0, 64'h007F_FFFF);
        send(0, 64'h8040_0000);
        send(1, 64'h0010_0000_0000_0000);
        send(1, 64'h7FEF_FFFF_FFFF_FFFF);
        send(0, 64'h0080_0000);
        send(0, 64'h7F7F_FFFF);
        idle();
        // random traffic with class bias and gaps
        for (int i = 0; i < 1500; i++) begin
            logic [63:0] d;
            bit f;
            int r;
            f = $urandom_range(0, 1);
            d = {$urandom, $urandom};
            r = $urandom_range(0, 7);
            if (f) begin
                if (r == 0) d[62:52] = '0;
                if (r == 1) d[62:52] = '1;
                if (r == 2) begin d[62:52] = '0; d[51:0] = d[51:0] >> $urandom_range(0, 51); end
            end else begin
                if (r == 0) d[30:23] = '0;
                if (r == 1) d[30:23] = '1;
                if (r == 2) begin d[30:23] = '0; d[22:0] = d[22:0] >> $urandom_range(0, 22); end
            end
            if (r == 3) begin if (f) d[51:0] = '0; else d[22:0] = '0; end
            send(f, d);
            if ($urandom_range(0, 3) == 0) idle();
        end
        idle();
        // R9: reset with operands in flight flushes them
        send(1, 64'h4000_0000_0000_0000);
        @(posedge clk); #2; in_valid = 1'b0; rst = 1'b1;
        due_q.delete(); val_q.delete(); tag_q.delete();
        repeat (2) @(posedge clk);
        #2; rst = 1'b0;
        send(0, 64'h0000_0000_4000_0000, "R9", 1, 80'h4000_8000_0000_0000_0000);
        idle();
        repeat (6) @(posedge clk);
        #2;
        if (due_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d results outstanding, expected 0", due_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule